// File: doc/BRIEF.md
# Posted Write Synchroniser for Slow-Tick Registers

This block sits between a fast host register port and a set of peripheral registers that may only change on a slow synchronisation strobe. A host write to one of the synchronised registers is not applied at once. It is captured as a single posted write, made of one address and one data word. The write lands in the addressed register on the next synchronisation strobe, and every other register keeps its value. Two status bits report progress. Bit 14 is the pending flag, which reads 1 while the posted write waits. Bit 15 is the done flag, which is set when the write lands and stays set until software clears it by writing 1 to it.

Only one write can be outstanding. A write to any synchronised register while the pending flag is 1 is dropped without trace. Writes to the status register bypass the posting path and take effect on the clock edge that carries them, even while a write is pending. A bit in the prescaler register selects the strobe. When the bit is 1 the slow strobe is used. When it is 0 the fast strobe is used. Both strobes arrive already synchronised into the host clock as single-cycle pulses. An interrupt output reports the done flag when bit 15 of the interrupt-enable register is set.

The control is a two-state machine. In IDLE nothing is held. The POST transition goes to HOLD when a write to a synchronised register arrives. In HOLD the posted address and data are frozen. The APPLY transition goes back to IDLE on the selected strobe, and it writes the register and raises the done flag.

Top module: `slowreg_post_sync`

## Requirements
- R1: After reset the synchronised registers read 0, except the prescaler register (address 2), which reads 1. The status register (address 5) reads 0 and irq is low.
- R2: A host write to a synchronised register (addresses 0 to 4) is posted. Until the strobe, reads return the old value, and status bit 14 reads 1 from the edge after the write.
- R3: On the selected strobe edge with a write posted, only the addressed register takes the posted data. Bit 14 clears and bit 15 sets on that same edge.
- R4: A write to any synchronised register while bit 14 is 1 is discarded. This includes a write on the very edge that applies the pending one. Only the first write's data ever appears.
- R5: Writing the status register with bit 15 = 1 clears the done flag on that edge, even while a write is pending. The pending flag and the posted write are unaffected, and the other data bits are ignored.
- R6: If a done-clear write and an APPLY fall on the same edge, the done flag ends up set.
- R7: irq is high exactly when the done flag is set and bit 15 of the interrupt-enable register (address 3) holds 1.
- R8: With prescaler bit 0 = 1 only tick_slow acts as the strobe. With it at 0 only tick_fast does. The other strobe is ignored.
- R9: Writes to addresses 6 and 7 are ignored. They post nothing and change no register.
- R10: A write that arrives in IDLE on the same edge as a strobe is posted, not applied. It lands on the following strobe.
- R11: A strobe with no posted write changes no register and does not set the done flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 3 | Host write address |
| wr_data | input | 32 | Host write data |
| rd_addr | input | 3 | Host read address |
| rd_data | output | 32 | Read data (combinational) |
| tick_slow | input | 1 | Slow synchronisation strobe, one cycle |
| tick_fast | input | 1 | Fast synchronisation strobe, one cycle |
| irq | output | 1 | Done-flag interrupt |

## Verification
The bench aims a second write at a pending one, both on a quiet cycle and on the exact edge of the strobe. A design that queued writes or let the last writer win would show the second register changed. It lands a fresh write on a strobe edge while idle. An over-eager design would apply that write at once instead of posting it. It also clears the done flag while a write is pending and on the edge of an APPLY. Wrong priority there would lose the pending flag or a completion. Finally it swaps the strobe source through the prescaler register. A design that ignored the selection would apply writes on the wrong strobe.

// File: rtl/slowreg_pkg.sv
package slowreg_pkg;

    // Status bit positions; software decodes these.
    localparam int PEND_BIT = 14;
    localparam int DONE_BIT = 15;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } post_state_e;

endpackage

// File: rtl/slowreg_post_fsm.sv
module slowreg_post_fsm
    import slowreg_pkg::*;
#(
    parameter int ADDR_W   = 3,
    parameter int DATA_W   = 32,
    parameter int NUM_SYNC = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              strobe,
    output logic              pending,
    output logic              apply,
    output logic [ADDR_W-1:0] post_addr,
    output logic [DATA_W-1:0] post_data
);

    localparam logic [ADDR_W-1:0] SYNC_LIMIT = ADDR_W'(NUM_SYNC);

    post_state_e state_q, state_d;
    logic        sync_hit;

    assign sync_hit = wr_en && (wr_addr < SYNC_LIMIT);

    // Next-state logic: POST and APPLY transitions.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (sync_hit) state_d = ST_HOLD;   // POST
            ST_HOLD: if (strobe)   state_d = ST_IDLE;   // APPLY
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Posted write capture; frozen while held, so later writes drop.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            post_addr <= '0;
            post_data <= '0;
        end else if (state_q == ST_IDLE && sync_hit) begin
            post_addr <= wr_addr;
            post_data <= wr_data;
        end
    end

    // Outputs.
    always_comb begin
        pending = 1'b0;
        apply   = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_HOLD: begin
                pending = 1'b1;
                apply   = strobe;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/slowreg_bank.sv
module slowreg_bank #(
    parameter int ADDR_W    = 3,
    parameter int DATA_W    = 32,
    parameter int NUM_SYNC  = 5,
    parameter int PRESC_IDX = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         apply,
    input  logic [ADDR_W-1:0]            post_addr,
    input  logic [DATA_W-1:0]            post_data,
    output logic [NUM_SYNC*DATA_W-1:0]   regs_flat
);

    for (genvar i = 0; i < NUM_SYNC; i++) begin : g_reg
        localparam logic [DATA_W-1:0] RST_VAL =
            (i == PRESC_IDX) ? DATA_W'(1) : '0;
        localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(i);
        logic [DATA_W-1:0] val_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                val_q <= RST_VAL;
            else if (apply && post_addr == MY_ADDR)
                val_q <= post_data;
        end

        assign regs_flat[i*DATA_W +: DATA_W] = val_q;
    end

endmodule

// File: rtl/slowreg_status.sv
module slowreg_status (
    input  logic clk,
    input  logic rst_n,
    input  logic apply,
    input  logic done_clr,
    input  logic irq_en,
    output logic done,
    output logic irq
);

    // A completion on the same edge as a clear wins.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        done <= 1'b0;
        else if (apply)    done <= 1'b1;
        else if (done_clr) done <= 1'b0;
    end

    assign irq = done && irq_en;

endmodule

// File: rtl/slowreg_post_sync.sv
module slowreg_post_sync
    import slowreg_pkg::*;
#(
    parameter int ADDR_W    = 3,
    parameter int DATA_W    = 32,
    parameter int NUM_SYNC  = 5,
    parameter int PRESC_IDX = 2,
    parameter int IEN_IDX   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              tick_slow,
    input  logic              tick_fast,
    output logic              irq
);

    localparam logic [ADDR_W-1:0] STAT_ADDR  = ADDR_W'(NUM_SYNC);
    localparam logic [ADDR_W-1:0] SYNC_LIMIT = ADDR_W'(NUM_SYNC);

    logic                       pending_w;
    logic                       apply_w;
    logic                       complete_w;
    logic                       strobe_w;
    logic                       done_clr;
    logic [ADDR_W-1:0]          post_addr;
    logic [DATA_W-1:0]          post_data;
    logic [NUM_SYNC*DATA_W-1:0] bank_flat;
    logic                       presc_on;
    logic                       ien_done;

    assign presc_on = bank_flat[PRESC_IDX*DATA_W];
    assign ien_done = bank_flat[IEN_IDX*DATA_W + DONE_BIT];
    assign strobe_w = presc_on ? tick_slow : tick_fast;
    assign done_clr = wr_en && (wr_addr == STAT_ADDR) && wr_data[DONE_BIT];

    slowreg_post_fsm #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .NUM_SYNC (NUM_SYNC)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .strobe    (strobe_w),
        .pending   (pending_w),
        .apply     (apply_w),
        .post_addr (post_addr),
        .post_data (post_data)
    );

    slowreg_bank #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .NUM_SYNC  (NUM_SYNC),
        .PRESC_IDX (PRESC_IDX)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .apply     (apply_w),
        .post_addr (post_addr),
        .post_data (post_data),
        .regs_flat (bank_flat)
    );

    slowreg_status u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .apply    (apply_w),
        .done_clr (done_clr),
        .irq_en   (ien_done),
        .done     (complete_w),
        .irq      (irq)
    );

    // Read mux: applied values only, never the posted word.
    always_comb begin
        rd_data = '0;
        if (rd_addr < SYNC_LIMIT) begin
            rd_data = bank_flat[rd_addr*DATA_W +: DATA_W];
        end else if (rd_addr == STAT_ADDR) begin
            rd_data[DONE_BIT] = complete_w;
            rd_data[PEND_BIT] = pending_w;
        end
    end

endmodule

// File: rtl/slowreg_post_sync_chk.sv
module slowreg_post_sync_chk #(
    parameter int ADDR_W   = 3,
    parameter int DATA_W   = 32,
    parameter int NUM_SYNC = 5
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       wr_en,
    input logic [ADDR_W-1:0]          wr_addr,
    input logic [DATA_W-1:0]          wr_data,
    input logic                       pending,
    input logic                       complete,
    input logic                       strobe,
    input logic [NUM_SYNC*DATA_W-1:0] bank_flat
);

    localparam logic [ADDR_W-1:0] LIM = ADDR_W'(NUM_SYNC);

    // R2: a held write stays held until a strobe
    p_pend_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pending && !strobe |=> pending);

    // R2: registers only move on an APPLY
    p_bank_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(pending && strobe) |=> $stable(bank_flat));

    // R3: APPLY clears pending and sets done
    p_apply_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pending && strobe |=> !pending && complete);

    // R4: a write during pending is dropped
    p_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pending && !strobe && wr_en && wr_addr < LIM |=> pending && $stable(bank_flat));

    // R5: done clear acts on the same edge when no APPLY competes
    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_addr == LIM && wr_data[15] && !(pending && strobe) |=> !complete);

    // R9: unmapped writes post nothing
    p_unmapped_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !pending && wr_en && wr_addr > LIM |=> !pending);

    // R11: done cannot appear without a posted write
    p_nodone_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !pending && !complete |=> !complete);

endmodule

bind slowreg_post_sync slowreg_post_sync_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .NUM_SYNC (NUM_SYNC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .pending   (pending_w),
    .complete  (complete_w),
    .strobe    (strobe_w),
    .bank_flat (bank_flat)
);

// File: tb/slowreg_post_sync_bench.sv
module slowreg_post_sync_bench;

    localparam logic [2:0] A_TIME = 3'd0, A_ALRM = 3'd1, A_PRSC = 3'd2,
                           A_IEN = 3'd3, A_SWCH = 3'd4, A_STAT = 3'd5;
    localparam logic [31:0] S_PEND = 32'h4000, S_DONE = 32'h8000;

    logic        clk = 0, rst_n = 0;
    logic        wr_en = 0, tick_slow = 0, tick_fast = 0;
    logic [2:0]  wr_addr = '0, rd_addr = '0;
    logic [31:0] wr_data = '0, rd_data;
    logic        irq;
    int          checks = 0, errors = 0;
    bit          done_run = 0;

    slowreg_post_sync u_slowreg_post_sync (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .tick_slow(tick_slow), .tick_fast(tick_fast), .irq(irq)
    );

    always #5 clk = ~clk;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic rd_chk(string tag, logic [2:0] a, logic [31:0] exp);
        rd_addr = a;
        #1;
        chk(tag, rd_data, exp);
    endtask

    // One edge with optional write and optional strobes.
    task automatic cyc(bit we, logic [2:0] a, logic [31:0] d, bit ts, bit tf);
        @(negedge clk);
        wr_en = we; wr_addr = a; wr_data = d; tick_slow = ts; tick_fast = tf;
        @(negedge clk);
        wr_en = 0; tick_slow = 0; tick_fast = 0;
    endtask

    task automatic t_reset;
        rd_chk("R1 time", A_TIME, 0);
        rd_chk("R1 presc", A_PRSC, 1);
        rd_chk("R1 ien", A_IEN, 0);
        rd_chk("R1 status", A_STAT, 0);
        chk("R1 irq", {31'd0, irq}, 0);
    endtask

    task automatic t_post_apply;
        cyc(1, A_TIME, 32'h1234_5678, 0, 0);
        rd_chk("R2 old value", A_TIME, 0);
        rd_chk("R2 pending", A_STAT, S_PEND);
        cyc(0, 0, 0, 0, 0);
        rd_chk("R2 still pending", A_STAT, S_PEND);
        cyc(0, 0, 0, 1, 0);
        rd_chk("R3 applied", A_TIME, 32'h1234_5678);
        rd_chk("R3 neighbour", A_ALRM, 0);
        rd_chk("R3 status done", A_STAT, S_DONE);
    endtask

    task automatic t_status_clear;
        cyc(1, A_STAT, 32'h7FFF, 0, 0);
        rd_chk("R5 other bits ignored", A_STAT, S_DONE);
        cyc(1, A_STAT, S_DONE, 0, 0);
        rd_chk("R5 cleared", A_STAT, 0);
    endtask

    task automatic t_discard;
        cyc(1, A_ALRM, 32'hAAAA_0001, 0, 0);
        cyc(1, A_SWCH, 32'hBBBB_0002, 0, 0);
        cyc(0, 0, 0, 1, 0);
        rd_chk("R4 first kept", A_ALRM, 32'hAAAA_0001);
        rd_chk("R4 second dropped", A_SWCH, 0);
        cyc(1, A_ALRM, 32'hCCCC_0003, 0, 0);
        cyc(1, A_SWCH, 32'hDDDD_0004, 1, 0);
        rd_chk("R4 edge write dropped", A_SWCH, 0);
        rd_chk("R4 edge apply", A_ALRM, 32'hCCCC_0003);
        rd_chk("R4 no new post", A_STAT, S_DONE);
        cyc(1, A_STAT, S_DONE, 0, 0);
    endtask

    task automatic t_post_on_tick;
        cyc(1, A_TIME, 32'h0E0E_0E0E, 1, 0);
        rd_chk("R10 not applied", A_TIME, 32'h1234_5678);
        rd_chk("R10 posted", A_STAT, S_PEND);
        cyc(0, 0, 0, 1, 0);
        rd_chk("R10 lands next", A_TIME, 32'h0E0E_0E0E);
        cyc(1, A_STAT, S_DONE, 0, 0);
    endtask

    task automatic t_idle_tick;
        cyc(0, 0, 0, 1, 0);
        rd_chk("R11 no done", A_STAT, 0);
        rd_chk("R11 time kept", A_TIME, 32'h0E0E_0E0E);
    endtask

    task automatic t_clear_pending;
        cyc(1, A_SWCH, 32'h55, 1, 0);
        cyc(0, 0, 0, 1, 0);          // done set
        cyc(1, A_TIME, 32'hF00D, 0, 0);
        rd_chk("R5 setup", A_STAT, S_DONE | S_PEND);
        cyc(1, A_STAT, S_DONE, 0, 0);
        rd_chk("R5 clear keeps pending", A_STAT, S_PEND);
        cyc(1, A_STAT, S_DONE, 1, 0);
        rd_chk("R6 set wins", A_STAT, S_DONE);
        rd_chk("R5 posted intact", A_TIME, 32'hF00D);
        cyc(1, A_STAT, S_DONE, 0, 0);
    endtask

    task automatic t_irq;
        cyc(1, A_IEN, S_DONE, 0, 0);
        cyc(0, 0, 0, 1, 0);
        chk("R7 irq on", {31'd0, irq}, 1);
        cyc(1, A_STAT, S_DONE, 0, 0);
        chk("R7 irq off after clear", {31'd0, irq}, 0);
        cyc(1, A_IEN, 32'h0, 0, 0);
        cyc(0, 0, 0, 1, 0);
        rd_chk("R7 done set", A_STAT, S_DONE);
        chk("R7 irq masked", {31'd0, irq}, 0);
        cyc(1, A_STAT, S_DONE, 0, 0);
    endtask

    task automatic t_fast;
        cyc(1, A_PRSC, 0, 0, 1);     // fast ignored at posting
        cyc(0, 0, 0, 0, 1);
        rd_chk("R8 fast ignored", A_STAT, S_PEND);
        cyc(0, 0, 0, 1, 0);
        rd_chk("R8 prescaler off", A_PRSC, 0);
        cyc(1, A_STAT, S_DONE, 0, 0);
        cyc(1, A_TIME, 32'h6666, 0, 0);
        cyc(0, 0, 0, 1, 0);
        rd_chk("R8 slow ignored", A_STAT, S_PEND);
        rd_chk("R8 time held", A_TIME, 32'hF00D);
        cyc(0, 0, 0, 0, 1);
        rd_chk("R8 fast applies", A_TIME, 32'h6666);
        cyc(1, A_STAT, S_DONE, 0, 0);
        cyc(1, A_PRSC, 1, 0, 0);
        cyc(0, 0, 0, 0, 1);
        rd_chk("R8 back to slow", A_PRSC, 1);
        cyc(1, A_STAT, S_DONE, 0, 0);
    endtask

    task automatic t_unmapped;
        cyc(1, 3'd6, 32'hFFFF_FFFF, 0, 0);
        rd_chk("R9 addr6 no post", A_STAT, 0);
        cyc(1, 3'd7, 32'hFFFF_FFFF, 0, 0);
        rd_chk("R9 addr7 no post", A_STAT, 0);
        cyc(0, 0, 0, 1, 0);
        rd_chk("R9 time unchanged", A_TIME, 32'h6666);
        rd_chk("R9 no done", A_STAT, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset;
        t_post_apply;
        t_status_clear;
        t_discard;
        t_post_on_tick;
        t_idle_tick;
        t_clear_pending;
        t_irq;
        t_fast;
        t_unmapped;
        done_run = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done_run) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule